// File: doc/BRIEF.md
# Timer Count-Tick Source Conditioner

This block sits in front of a general-purpose timer counter and decides, once per system clock, whether the counter may advance. It takes three possible sources and produces one count-enable output. The first source is the system clock itself. The second is an external trigger pin, which has optional inversion, a glitch filter and a power-of-two event divider. The third is a timer input pin, with a glitch filter and a choice of which edges count. Both pins are asynchronous, so each passes through a two-flop synchroniser before any other logic sees it.

All configuration arrives on static input ports. A small source code picks the path. There are two trigger modes. The filtered mode uses the glitch filter. The fast mode bypasses the filter and only synchronises the pin. Every qualified event yields exactly one registered tick of one clock width. On the trigger path a tick is produced only once per 2^k events. The event divider restarts from zero whenever the source code or the divide ratio changes.

Top module: `tck_cond`

## Requirements
- R1: With src_sel_i = 0 (internal source), tick_o is high in every cycle from the first clock edge after reset release onward.
- R2: With filter setting N = filt_i (0..15), the filtered copy of a synchronised pin takes a new level only after the synchronised value has differed from the filtered level on max(N,1) consecutive clocks. So a pin change first sampled at edge k yields its tick after edge k+2+max(N,1), and a pulse shorter than max(N,1) clocks yields no tick.
- R3: On the trigger path the synchronised pin is inverted when trg_inv_i = 1 and passed unchanged when it is 0, and events are rising edges of the result. With trg_inv_i = 1, a falling pin therefore counts and a rising pin does not. The trigger path never ticks while its pin, polarity, source and filter setting are all unchanged.
- R4: With src_sel_i = 3 (timer input), edge_sel_i chooses the edges of the filtered input that count: 0 rising, 1 falling, 2 both, 3 none. This path has no event divider. It never ticks while its pin and configuration are unchanged.
- R5: With src_sel_i = 1 or 2 (trigger sources), tick_o pulses once per 2^psc_sel_i events (psc_sel_i 0..3 gives 1, 2, 4 or 8). The first tick comes on event number 2^psc_sel_i after the divider was cleared.
- R6: With src_sel_i = 2 (fast trigger), the glitch filter is bypassed. A trigger rise first sampled at edge k ticks after edge k+2, whatever filt_i is.
- R7: The event divider is cleared whenever src_sel_i or psc_sel_i differs from its value in the previous cycle.
- R8: While rst_ni is low, tick_o is low.
- R9: src_sel_i codes 5, 6 and 7 produce no tick.
- R10: With src_sel_i = 4 (timer input, both edges), every rising and every falling edge of the filtered input ticks, whatever edge_sel_i is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trg_i | input | 1 | External trigger pin, asynchronous |
| tin_i | input | 1 | Timer input pin, asynchronous |
| src_sel_i | input | 3 | Source code: 0 internal, 1 filtered trigger, 2 fast trigger, 3 timer input, 4 timer input both edges |
| trg_inv_i | input | 1 | Invert trigger before use |
| edge_sel_i | input | 2 | Timer input edge choice: 0 rise, 1 fall, 2 both, 3 none |
| psc_sel_i | input | 2 | Trigger event divider, ratio 2^psc_sel_i |
| filt_i | input | 4 | Glitch filter setting N |
| tick_o | output | 1 | Single-cycle count-enable pulse |

## Verification
A pin change driven just before edge k passes two synchroniser flops, max(N,1) filter clocks and one output register. Its tick is therefore due after edge k+2+max(N,1), or after edge k+2 on the fast trigger path. The bench drives every pin at the falling edge and samples tick_o a quarter period after each rising edge. It records the index of the first rising edge that shows a tick and compares that index with the formula for every filter setting from 0 to 15. Divider, edge and polarity checks count ticks over windows long enough to cover the longest filter latency. Each configuration change is followed by a settling gap, so no count starts while an earlier event is still in flight.

// File: rtl/tck_pkg.sv
package tck_pkg;
  typedef enum logic [2:0] {
    SRC_INT      = 3'd0,
    SRC_TRG_FILT = 3'd1,
    SRC_TRG_RAW  = 3'd2,
    SRC_TIN      = 3'd3,
    SRC_TIN_BOTH = 3'd4
  } src_e;

  typedef enum logic [1:0] {
    EDGE_RISE = 2'd0,
    EDGE_FALL = 2'd1,
    EDGE_BOTH = 2'd2,
    EDGE_NONE = 2'd3
  } edge_e;
endpackage

// File: rtl/tck_sync.sv
module tck_sync #(
  parameter int WIDTH  = 1,
  parameter int STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/tck_filter.sv
module tck_filter #(
  parameter int CFG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             d_i,
  input  logic [CFG_W-1:0] n_i,
  output logic             q_o
);
  logic [CFG_W-1:0] run_q;
  logic             lvl_q;
  logic [CFG_W:0]   run_nx;

  assign run_nx = {1'b0, run_q} + 1'b1;

  // level moves once the mismatch has been seen max(n,1) times in a row
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q <= '0;
      lvl_q <= 1'b0;
    end else if (d_i == lvl_q) begin
      run_q <= '0;
    end else if (run_nx >= {1'b0, n_i}) begin
      lvl_q <= d_i;
      run_q <= '0;
    end else begin
      run_q <= run_nx[CFG_W-1:0];
    end
  end

  assign q_o = lvl_q;
endmodule

// File: rtl/tck_edge.sv
module tck_edge #(
  parameter int WIDTH = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] rise_o,
  output logic [WIDTH-1:0] fall_o
);
  logic [WIDTH-1:0] prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= d_i;
  end

  assign rise_o = d_i & ~prev_q;
  assign fall_o = ~d_i & prev_q;
endmodule

// File: rtl/tck_prescale.sv
module tck_prescale #(
  parameter int SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             evt_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic             fire_o
);
  localparam int CNT_W = (1 << SEL_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W:0]   span;

  assign span   = ({{CNT_W{1'b0}}, 1'b1} << sel_i) - 1'b1;
  assign fire_o = evt_i & ~clr_i & (cnt_q == span[CNT_W-1:0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (clr_i)  cnt_q <= '0;
    else if (fire_o) cnt_q <= '0;
    else if (evt_i)  cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/tck_cond.sv
module tck_cond
  import tck_pkg::*;
#(
  parameter int FILT_W      = 4,
  parameter int PSC_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              trg_i,
  input  logic              tin_i,
  input  logic [2:0]        src_sel_i,
  input  logic              trg_inv_i,
  input  logic [1:0]        edge_sel_i,
  input  logic [PSC_W-1:0]  psc_sel_i,
  input  logic [FILT_W-1:0] filt_i,
  output logic              tick_o
);
  localparam int NPIN  = 2;
  localparam int NEDGE = 3;

  logic [NPIN-1:0]  pin_s;
  logic             trg_pol;
  logic [NPIN-1:0]  flt_in;
  logic [NPIN-1:0]  flt_q;
  logic [NEDGE-1:0] ed_in, ed_rise, ed_fall;
  logic [2:0]       src_q;
  logic [PSC_W-1:0] psc_q;
  logic             cfg_chg, trg_src, psc_evt, psc_fire;
  logic             tick_d, tick_q;

  tck_sync #(.WIDTH(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({tin_i, trg_i}),
    .q_o    (pin_s)
  );

  assign trg_pol = pin_s[0] ^ trg_inv_i;
  assign flt_in  = {pin_s[1], trg_pol};

  for (genvar g = 0; g < NPIN; g++) begin : g_flt
    tck_filter #(.CFG_W(FILT_W)) u_flt (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .d_i    (flt_in[g]),
      .n_i    (filt_i),
      .q_o    (flt_q[g])
    );
  end

  // bit0 filtered trigger, bit1 filtered timer input, bit2 unfiltered trigger
  assign ed_in = {trg_pol, flt_q[1], flt_q[0]};

  tck_edge #(.WIDTH(NEDGE)) u_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (ed_in),
    .rise_o (ed_rise),
    .fall_o (ed_fall)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q <= SRC_INT;
      psc_q <= '0;
    end else begin
      src_q <= src_sel_i;
      psc_q <= psc_sel_i;
    end
  end

  assign cfg_chg = (src_q != src_sel_i) | (psc_q != psc_sel_i);
  assign trg_src = (src_sel_i == SRC_TRG_FILT) | (src_sel_i == SRC_TRG_RAW);
  assign psc_evt = ((src_sel_i == SRC_TRG_FILT) & ed_rise[0])
                 | ((src_sel_i == SRC_TRG_RAW)  & ed_rise[2]);

  tck_prescale #(.SEL_W(PSC_W)) u_psc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cfg_chg | ~trg_src),
    .evt_i  (psc_evt),
    .sel_i  (psc_sel_i),
    .fire_o (psc_fire)
  );

  always_comb begin
    case (src_sel_i)
      SRC_INT:                   tick_d = 1'b1;
      SRC_TRG_FILT, SRC_TRG_RAW: tick_d = psc_fire;
      SRC_TIN: begin
        case (edge_sel_i)
          EDGE_RISE: tick_d = ed_rise[1];
          EDGE_FALL: tick_d = ed_fall[1];
          EDGE_BOTH: tick_d = ed_rise[1] | ed_fall[1];
          default:   tick_d = 1'b0;
        endcase
      end
      SRC_TIN_BOTH:              tick_d = ed_rise[1] | ed_fall[1];
      default:                   tick_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= tick_d;
  end

  assign tick_o = tick_q;
endmodule

// File: rtl/tck_cond_chk.sv
module tck_cond_chk #(
  parameter int FILT_W = 4,
  parameter int PSC_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              trg_i,
  input logic              tin_i,
  input logic [2:0]        src_sel_i,
  input logic              trg_inv_i,
  input logic [1:0]        edge_sel_i,
  input logic [PSC_W-1:0]  psc_sel_i,
  input logic [FILT_W-1:0] filt_i,
  input logic              tick_o
);
  localparam int QUIET = (1 << FILT_W) + 8;
  localparam int CW    = $clog2(QUIET + 1);

  logic              trg_q, tin_q, inv_q;
  logic [2:0]        src_q;
  logic [1:0]        edge_q;
  logic [FILT_W-1:0] filt_q;
  logic [CW-1:0]     trg_run, tin_run;
  logic              trg_moved, tin_moved;

  assign trg_moved = (trg_i != trg_q) | (trg_inv_i != inv_q) | (src_sel_i != src_q) | (filt_i != filt_q);
  assign tin_moved = (tin_i != tin_q) | (edge_sel_i != edge_q) | (src_sel_i != src_q) | (filt_i != filt_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trg_q <= 1'b0; tin_q <= 1'b0; inv_q <= 1'b0;
      src_q <= '0; edge_q <= '0; filt_q <= '0;
      trg_run <= '0; tin_run <= '0;
    end else begin
      trg_q <= trg_i; tin_q <= tin_i; inv_q <= trg_inv_i;
      src_q <= src_sel_i; edge_q <= edge_sel_i; filt_q <= filt_i;
      if (trg_moved) trg_run <= '0;
      else if (trg_run != CW'(QUIET)) trg_run <= trg_run + 1'b1;
      if (tin_moved) tin_run <= '0;
      else if (tin_run != CW'(QUIET)) tin_run <= tin_run + 1'b1;
    end
  end

  always @(posedge clk_i) begin
    if (!rst_ni) begin
      AST_RESET_QUIET: assert (!tick_o) else $error("tick during reset"); // R8
    end
  end

  AST_INT_EVERY_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(src_sel_i) == 3'd0) |-> tick_o); // R1

  AST_BAD_SEL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(src_sel_i) > 3'd4) |-> !tick_o); // R9

  AST_TRG_NO_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (trg_run == CW'(QUIET) && (src_sel_i == 3'd1 || src_sel_i == 3'd2)) |-> !tick_o); // R3

  AST_TIN_NO_EVENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tin_run == CW'(QUIET) && (src_sel_i == 3'd3 || src_sel_i == 3'd4)) |-> !tick_o); // R4
endmodule

bind tck_cond tck_cond_chk #(.FILT_W(FILT_W), .PSC_W(PSC_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .trg_i      (trg_i),
  .tin_i      (tin_i),
  .src_sel_i  (src_sel_i),
  .trg_inv_i  (trg_inv_i),
  .edge_sel_i (edge_sel_i),
  .psc_sel_i  (psc_sel_i),
  .filt_i     (filt_i),
  .tick_o     (tick_o)
);

// File: tb/tck_cond_bench.sv
`timescale 1ns/1ps
module tck_cond_bench;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       trg_i = 1'b0;
  logic       tin_i = 1'b0;
  logic [2:0] src_sel_i = 3'd0;
  logic       trg_inv_i = 1'b0;
  logic [1:0] edge_sel_i = 2'd0;
  logic [1:0] psc_sel_i = 2'd0;
  logic [3:0] filt_i = 4'd0;
  logic       tick_o;

  int checks = 0;
  int errors = 0;
  int tick_cnt = 0;
  bit done = 0;

  always #10 clk_i = ~clk_i;

  tck_cond u_tck_cond (
    .clk_i(clk_i), .rst_ni(rst_ni), .trg_i(trg_i), .tin_i(tin_i),
    .src_sel_i(src_sel_i), .trg_inv_i(trg_inv_i), .edge_sel_i(edge_sel_i),
    .psc_sel_i(psc_sel_i), .filt_i(filt_i), .tick_o(tick_o)
  );

  always @(posedge clk_i) begin
    #5;
    if (tick_o === 1'b1) tick_cnt++;
  end

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic set_cfg(input int src, input bit inv, input int edg, input int psc, input int n);
    @(negedge clk_i);
    src_sel_i = 3'(src); trg_inv_i = inv; edge_sel_i = 2'(edg);
    psc_sel_i = 2'(psc); filt_i = 4'(n);
    repeat (40) @(negedge clk_i);
  endtask

  task automatic drive(input int which, input bit val);
    if (which == 0) trg_i = val; else tin_i = val;
  endtask

  task automatic pulse(input int which, input int width, input int gap);
    @(negedge clk_i);
    drive(which, 1'b1);
    repeat (width) @(negedge clk_i);
    drive(which, 1'b0);
    repeat (gap) @(negedge clk_i);
  endtask

  // drive at negedge, report index of first posedge showing a tick and total ticks
  task automatic measure(input int which, input bit val, output int first, output int cnt);
    first = 0; cnt = 0;
    @(negedge clk_i);
    drive(which, val);
    for (int i = 1; i <= 40; i++) begin
      @(posedge clk_i); #5;
      if (tick_o === 1'b1) begin
        cnt++;
        if (first == 0) first = i;
      end
    end
    @(negedge clk_i);
  endtask

  task automatic summary;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual 0 expected 1");
      summary();
    end
  end

  initial begin
    int first, cnt, base, m;
    repeat (4) @(posedge clk_i);
    #5 chk("R8 tick low in reset", int'(tick_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    base = tick_cnt;
    repeat (20) @(negedge clk_i);
    chk("R1 internal tick every cycle", tick_cnt - base, 20);

    // R2 latency sweep on timer input, rising edges
    for (int n = 0; n < 16; n++) begin
      set_cfg(3, 0, 0, 0, n);
      m = (n > 1) ? n : 1;
      measure(1, 1'b1, first, cnt);
      chk($sformatf("R2 latency n=%0d", n), first, 3 + m);
      chk($sformatf("R2 single tick n=%0d", n), cnt, 1);
      measure(1, 1'b0, first, cnt);
      chk($sformatf("R4 fall ignored in rise mode n=%0d", n), cnt, 0);
    end

    // R2 glitch rejection
    for (int k = 0; k < 3; k++) begin
      int n = (k == 0) ? 2 : (k == 1) ? 5 : 15;
      set_cfg(3, 0, 0, 0, n);
      base = tick_cnt;
      pulse(1, n - 1, 40);
      chk($sformatf("R2 short pulse rejected n=%0d", n), tick_cnt - base, 0);
      base = tick_cnt;
      pulse(1, n, 40);
      chk($sformatf("R2 full pulse passes n=%0d", n), tick_cnt - base, 1);
    end

    // R4 edge choices, R10 both-edge source
    for (int e = 0; e < 4; e++) begin
      set_cfg(3, 0, e, 0, 0);
      base = tick_cnt;
      for (int p = 0; p < 3; p++) pulse(1, 3, 10);
      chk($sformatf("R4 edge_sel=%0d", e), tick_cnt - base,
          (e == 0 || e == 1) ? 3 : (e == 2) ? 6 : 0);
      set_cfg(4, 0, e, 0, 0);
      base = tick_cnt;
      for (int p = 0; p < 3; p++) pulse(1, 3, 10);
      chk($sformatf("R10 both edges edge_sel=%0d", e), tick_cnt - base, 6);
    end

    // R3 polarity
    set_cfg(1, 0, 0, 0, 0);
    measure(0, 1'b1, first, cnt);
    chk("R3 plain rise latency", first, 4);
    chk("R3 plain rise count", cnt, 1);
    measure(0, 1'b0, first, cnt);
    chk("R3 plain fall count", cnt, 0);
    set_cfg(1, 1, 0, 0, 0);
    measure(0, 1'b1, first, cnt);
    chk("R3 inverted rise count", cnt, 0);
    measure(0, 1'b0, first, cnt);
    chk("R3 inverted fall count", cnt, 1);
    set_cfg(1, 0, 0, 0, 0);

    // R5 divider ratios
    for (int psc = 0; psc < 4; psc++) begin
      int pre = (1 << psc) - 1;
      set_cfg(1, 0, 0, psc, 0);
      base = tick_cnt;
      for (int p = 0; p < pre; p++) pulse(0, 2, 4);
      chk($sformatf("R5 no tick before event %0d", pre + 1), tick_cnt - base, 0);
      for (int p = pre; p < 16; p++) pulse(0, 2, 4);
      repeat (6) @(negedge clk_i);
      chk($sformatf("R5 ratio psc=%0d", psc), tick_cnt - base, 16 >> psc);
    end

    // R7 divider cleared on ratio change and on source change
    set_cfg(1, 0, 0, 3, 0);
    for (int p = 0; p < 5; p++) pulse(0, 2, 4);
    set_cfg(1, 0, 0, 2, 0);
    base = tick_cnt;
    for (int p = 0; p < 3; p++) pulse(0, 2, 6);
    chk("R7 ratio change clears, 3 events", tick_cnt - base, 0);
    pulse(0, 2, 6);
    chk("R7 ratio change clears, 4th event", tick_cnt - base, 1);
    set_cfg(1, 0, 0, 3, 0);
    for (int p = 0; p < 5; p++) pulse(0, 2, 4);
    set_cfg(2, 0, 0, 3, 0);
    base = tick_cnt;
    for (int p = 0; p < 7; p++) pulse(0, 2, 6);
    chk("R7 source change clears, 7 events", tick_cnt - base, 0);
    pulse(0, 2, 6);
    chk("R7 source change clears, 8th event", tick_cnt - base, 1);

    // R6 fast trigger ignores filter
    set_cfg(2, 0, 0, 0, 15);
    measure(0, 1'b1, first, cnt);
    chk("R6 fast latency", first, 3);
    chk("R6 fast count", cnt, 1);
    measure(0, 1'b0, first, cnt);
    base = tick_cnt;
    pulse(0, 3, 30);
    chk("R6 fast short pulse passes", tick_cnt - base, 1);
    set_cfg(1, 0, 0, 0, 15);
    base = tick_cnt;
    pulse(0, 3, 30);
    chk("R6 filtered short pulse rejected", tick_cnt - base, 0);

    // R9 unused codes
    for (int s = 5; s < 8; s++) begin
      set_cfg(s, 0, 2, 0, 0);
      base = tick_cnt;
      for (int p = 0; p < 3; p++) begin
        pulse(0, 3, 6);
        pulse(1, 3, 6);
      end
      chk($sformatf("R9 code %0d silent", s), tick_cnt - base, 0);
    end

    done = 1;
    summary();
  end
endmodule